// File: doc/BRIEF.md
# Bus Access Permission Checker

This block sits between the bus masters and the on-chip peripheral space and decides, in the same cycle, whether an access may go ahead. Each request names a master, a privilege bit (supervisor or user), an access kind (instruction fetch, operand read or operand write) and a target index. The block first works out the effective privilege of the request from a per-master trust setting. It then looks up the rights that apply to the target and answers with either a grant, which raises the target's select line, or an error response, which leaves all selects low.

Three sets of rights are held. Seventeen individually controlled peripherals each have a supervisor-only flag and a write-protect flag. A set of fourteen further peripherals shares one rights code. The flash region has a second rights code of its own. A coded rights value can grant read, write and execute separately for supervisor and user. All control state is read and written through an 8-bit register port. Only trusted masters may change it.

Top module: `bus_perm_check`

## Requirements
- R1: `req_kind` uses 0 for instruction fetch, 1 for operand read and 2 for operand write. `req_priv` = 1 means supervisor. Kind 3 is always denied.
- R2: The effective privilege is supervisor only when `req_priv` is 1 and the master's trust bit (bit m of the trust register for master m) is 1. A master whose bit is 0 is treated as user whatever it signals.
- R3: While reset is asserted and until the first rising clock edge after its release, the trust register reads 0x01 (master 0 trusted). On that edge, bit i for each master i ≥ 1 is loaded from `trust_strap[i]`, and bit 0 stays set.
- R4: A register write from a master whose trust bit is 0 raises `reg_wr_err` in the same cycle and changes no register. A write from a trusted master leaves `reg_wr_err` low.
- R5: Register addresses are: 0 trust register (8 bits, bit m = master m), 1 to 9 individual-rights registers 0 to 8, 10 shared-set code, 11 flash code (codes in bits 3:0, bits 7:4 read 0). Addresses 12 to 15 read 0 and ignore writes. `reg_rdata` follows `reg_addr` without delay.
- R6: Individual-rights register k holds peripheral 2k in bits 7:4 and peripheral 2k+1 in bits 3:0. Register 8 holds peripheral 16 in bits 7:4, and its bits 3:0 read 0. In each nibble, bit 3 = write-protect (denies operand writes at any privilege) and bit 2 = supervisor-only (denies user accesses). Bits 1:0 read 0. Fetches to these peripherals are judged as reads.
- R7: Code rights, listed as supervisor read/write/execute then user read/write/execute: 0 = SR SW; 1 = SR; 2 = SR SW SX; 3 = SR SX; 4 = SR SW UR; 5 = SR SW UR UW; 6 = SR SW SX UR UX; 7 = all six; 8 = SR UR; 9 = SR SX UR UX.
- R8: Codes 10 to 15 deny every access to the targets they govern.
- R9: After reset, every individual-rights nibble is supervisor-only with no write-protect (registers 0 to 7 read 0x44, register 8 reads 0x40), and both codes read 0.
- R10: With `req_valid` high, exactly one of `req_grant` and `req_error` is high in the same cycle. With `req_valid` low, both are low.
- R11: `periph_sel` has bit t set only when the request to target t is granted, and is all zero otherwise.
- R12: Target indices 0 to 16 are the individual peripherals, 17 to 30 the shared set (code at address 10), and 31 the flash region (code at address 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trust_strap | input | 7 | Trust straps for masters 1 to 7, loaded after reset |
| req_valid | input | 1 | Access request present |
| req_mstr | input | 3 | Requesting master |
| req_priv | input | 1 | Signalled privilege, 1 = supervisor |
| req_kind | input | 2 | Access kind |
| req_periph | input | 5 | Target index |
| req_grant | output | 1 | Access allowed |
| req_error | output | 1 | Access denied, error response |
| periph_sel | output | 32 | One-hot target select, granted accesses only |
| reg_wr | input | 1 | Register write strobe |
| reg_mstr | input | 3 | Master issuing the register access |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_wr_err | output | 1 | Register write rejected |

## Verification
The answer path holds no state, so a corrupted flag or code shows up on the very next request to the affected target. It appears as a wrong grant/error pair and a missing or extra select bit, and the register port reads back the faulty value at once. A trust bit that is wrong changes three things in the same cycle: the effective privilege of every access from that master, the outcome of its register writes and the `reg_wr_err` flag. A strap load that is missed or mistimed is visible on the trust register at the first or second clock after reset release.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic sup_rd;
    logic sup_wr;
    logic sup_ex;
    logic usr_rd;
    logic usr_wr;
    logic usr_ex;
  } grp_rights_t;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned CODE_W = 4;

endpackage

// File: rtl/bpc_grp_decode.sv
module bpc_grp_decode
  import bpc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output grp_rights_t       rights_o
);

  // field order: sup rd, sup wr, sup ex, usr rd, usr wr, usr ex
  always_comb begin
    case (code_i)
      4'd0:    rights_o = grp_rights_t'(6'b110_000);
      4'd1:    rights_o = grp_rights_t'(6'b100_000);
      4'd2:    rights_o = grp_rights_t'(6'b111_000);
      4'd3:    rights_o = grp_rights_t'(6'b101_000);
      4'd4:    rights_o = grp_rights_t'(6'b110_100);
      4'd5:    rights_o = grp_rights_t'(6'b110_110);
      4'd6:    rights_o = grp_rights_t'(6'b111_101);
      4'd7:    rights_o = grp_rights_t'(6'b111_111);
      4'd8:    rights_o = grp_rights_t'(6'b100_100);
      4'd9:    rights_o = grp_rights_t'(6'b101_101);
      default: rights_o = grp_rights_t'(6'b000_000);
    endcase
  end

endmodule

// File: rtl/bpc_regs.sv
module bpc_regs
  import bpc_pkg::*;
#(
  parameter  int unsigned N_MASTERS = 8,
  parameter  int unsigned N_PERIPH  = 17,
  localparam int unsigned MW        = $clog2(N_MASTERS),
  localparam int unsigned N_PACR    = (N_PERIPH + 1) / 2,
  localparam int unsigned AW        = $clog2(N_PACR + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_MASTERS-1:1]     strap_i,
  input  logic                     wr_i,
  input  logic [MW-1:0]            wr_mstr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic                     wr_err_o,
  output logic [N_MASTERS-1:0]     mpr_o,
  output logic [N_PERIPH-1:0]      wp_o,
  output logic [N_PERIPH-1:0]      so_o,
  output logic [1:0][CODE_W-1:0]   code_o
);

  localparam logic [AW-1:0]        A_TRUST = '0;
  localparam logic [AW-1:0]        A_CODE0 = AW'(N_PACR + 1);
  localparam logic [AW-1:0]        A_CODE1 = AW'(N_PACR + 2);
  localparam logic [N_MASTERS-1:0] TRUST_RST = N_MASTERS'(1);

  logic wr_trusted, wr_ok;

  assign wr_trusted = mpr_o[wr_mstr_i];
  assign wr_ok      = wr_i & wr_trusted;
  assign wr_err_o   = wr_i & ~wr_trusted;

  // ---------------- trust register with post-reset strap load ----------
  logic [N_MASTERS-1:0] mpr_q, mpr_d;
  logic                 load_q, load_d;
  logic                 mpr_en;

  always_comb begin
    mpr_d  = mpr_q;
    load_d = 1'b0;
    if (load_q) mpr_d[N_MASTERS-1:1] = strap_i;
    if (wr_ok && (addr_i == A_TRUST)) mpr_d = wdata_i[N_MASTERS-1:0];
    mpr_en = load_q | (wr_ok && (addr_i == A_TRUST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpr_q  <= TRUST_RST;
      load_q <= 1'b1;
    end else begin
      load_q <= load_d;
      if (mpr_en) mpr_q <= mpr_d;
    end
  end

  assign mpr_o = mpr_q;

  // ---------------- per-peripheral flag pairs -------------------------
  for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
    localparam int unsigned K   = p / 2;
    localparam int unsigned WPB = ((p % 2) == 0) ? 7 : 3;
    logic wp_q, so_q, wp_d, so_d, en;

    always_comb begin
      en   = wr_ok && (addr_i == AW'(K + 1));
      wp_d = wdata_i[WPB];
      so_d = wdata_i[WPB-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp_q <= 1'b0;
        so_q <= 1'b1;
      end else if (en) begin
        wp_q <= wp_d;
        so_q <= so_d;
      end
    end

    assign wp_o[p] = wp_q;
    assign so_o[p] = so_q;
  end

  // ---------------- grouped codes -------------------------------------
  for (genvar g = 0; g < 2; g++) begin : g_code
    localparam logic [AW-1:0] A_MINE = (g == 0) ? A_CODE0 : A_CODE1;
    logic [CODE_W-1:0] code_q, code_d;
    logic              en;

    always_comb begin
      en     = wr_ok && (addr_i == A_MINE);
      code_d = wdata_i[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= '0;
      else if (en) code_q <= code_d;
    end

    assign code_o[g] = code_q;
  end

  // ---------------- read path -----------------------------------------
  logic [2*N_PACR-1:0] wp_pad, so_pad;

  assign wp_pad = (2*N_PACR)'(wp_o);
  assign so_pad = (2*N_PACR)'(so_o);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_TRUST) rdata_o = REG_W'(mpr_q);
    for (int k = 0; k < N_PACR; k++) begin
      if (addr_i == AW'(k + 1))
        rdata_o = {wp_pad[2*k], so_pad[2*k], 2'b00,
                   wp_pad[2*k+1], so_pad[2*k+1], 2'b00};
    end
    if (addr_i == A_CODE0) rdata_o = REG_W'(code_o[0]);
    if (addr_i == A_CODE1) rdata_o = REG_W'(code_o[1]);
  end

endmodule

// File: rtl/bus_perm_check.sv
module bus_perm_check
  import bpc_pkg::*;
#(
  parameter  int unsigned N_MASTERS = 8,
  parameter  int unsigned N_PERIPH  = 17,
  parameter  int unsigned N_GROUPED = 14,
  localparam int unsigned NT        = N_PERIPH + N_GROUPED + 1,
  localparam int unsigned TW        = $clog2(NT),
  localparam int unsigned MW        = $clog2(N_MASTERS),
  localparam int unsigned N_PACR    = (N_PERIPH + 1) / 2,
  localparam int unsigned AW        = $clog2(N_PACR + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:1] trust_strap,
  input  logic                 req_valid,
  input  logic [MW-1:0]        req_mstr,
  input  logic                 req_priv,
  input  logic [1:0]           req_kind,
  input  logic [TW-1:0]        req_periph,
  output logic                 req_grant,
  output logic                 req_error,
  output logic [NT-1:0]        periph_sel,
  input  logic                 reg_wr,
  input  logic [MW-1:0]        reg_mstr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 reg_wr_err
);

  localparam int unsigned   PW        = $clog2(N_PERIPH);
  localparam logic [TW-1:0] IDX_GRP0  = TW'(N_PERIPH);
  localparam logic [TW-1:0] IDX_FLASH = TW'(N_PERIPH + N_GROUPED);

  logic [N_MASTERS-1:0]   mpr_q;
  logic [N_PERIPH-1:0]    pacr_wp, pacr_so;
  logic [1:0][CODE_W-1:0] grp_code;
  grp_rights_t [1:0]      rights_g;

  bpc_regs #(
    .N_MASTERS (N_MASTERS),
    .N_PERIPH  (N_PERIPH)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (trust_strap),
    .wr_i      (reg_wr),
    .wr_mstr_i (reg_mstr),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .rdata_o   (reg_rdata),
    .wr_err_o  (reg_wr_err),
    .mpr_o     (mpr_q),
    .wp_o      (pacr_wp),
    .so_o      (pacr_so),
    .code_o    (grp_code)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dec
    bpc_grp_decode u_dec (
      .code_i   (grp_code[g]),
      .rights_o (rights_g[g])
    );
  end

  // ---------------- access judgement ----------------------------------
  acc_kind_e   kind;
  logic        eff_sup, in_indiv, in_grp0, in_flash;
  logic        so_bit, wp_bit, ind_ok, grp_ok, allowed;
  grp_rights_t rights;

  assign kind = acc_kind_e'(req_kind);

  always_comb begin
    eff_sup  = req_priv & mpr_q[req_mstr];
    in_indiv = req_periph < IDX_GRP0;
    in_flash = req_periph == IDX_FLASH;
    in_grp0  = !in_indiv && (req_periph < IDX_FLASH);
    rights   = in_flash ? rights_g[1] : rights_g[0];
    so_bit   = pacr_so[req_periph[PW-1:0]];
    wp_bit   = pacr_wp[req_periph[PW-1:0]];
    case (kind)
      ACC_FETCH: begin
        ind_ok = !(so_bit && !eff_sup);
        grp_ok = eff_sup ? rights.sup_ex : rights.usr_ex;
      end
      ACC_READ: begin
        ind_ok = !(so_bit && !eff_sup);
        grp_ok = eff_sup ? rights.sup_rd : rights.usr_rd;
      end
      ACC_WRITE: begin
        ind_ok = !(so_bit && !eff_sup) && !wp_bit;
        grp_ok = eff_sup ? rights.sup_wr : rights.usr_wr;
      end
      default: begin
        ind_ok = 1'b0;
        grp_ok = 1'b0;
      end
    endcase
    if (in_indiv)                 allowed = ind_ok;
    else if (in_grp0 || in_flash) allowed = grp_ok;
    else                          allowed = 1'b0;
  end

  assign req_grant = req_valid & allowed;
  assign req_error = req_valid & ~allowed;

  for (genvar t = 0; t < NT; t++) begin : g_sel
    assign periph_sel[t] = req_grant && (req_periph == TW'(t));
  end

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int unsigned N_MASTERS = 8,
  parameter int unsigned NT        = 32,
  parameter int unsigned CFG_W     = 50,
  parameter int unsigned MW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_grant,
  input logic                 req_error,
  input logic [NT-1:0]        periph_sel,
  input logic                 reg_wr,
  input logic                 reg_wr_err,
  input logic [MW-1:0]        reg_mstr,
  input logic [N_MASTERS-1:0] mpr,
  input logic [CFG_W-1:0]     cfg
);

  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R3: core master trusted on the first edge after reset release
  p_core_trusted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> mpr[0]);

  // R4: rejected write leaves every control bit unchanged
  p_untrusted_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mpr[reg_mstr] && started) |=> $stable(cfg));

  // R4: error flag only accompanies a write strobe
  p_wr_err_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_err |-> reg_wr);

  // R10: valid request answered by exactly one response
  p_resp_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_grant ^ req_error));

  // R10: no response without a request
  p_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_grant && !req_error));

  // R11: select is one-hot and present exactly on grant
  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_sel) && ((|periph_sel) == req_grant));

endmodule

bind bus_perm_check bpc_checker #(
  .N_MASTERS (N_MASTERS),
  .NT        (NT),
  .CFG_W     (N_MASTERS + 2*N_PERIPH + 8),
  .MW        (MW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_grant  (req_grant),
  .req_error  (req_error),
  .periph_sel (periph_sel),
  .reg_wr     (reg_wr),
  .reg_wr_err (reg_wr_err),
  .reg_mstr   (reg_mstr),
  .mpr        (mpr_q),
  .cfg        ({mpr_q, pacr_wp, pacr_so, grp_code})
);

// File: tb/bus_perm_check_tb.sv
`timescale 1ns/1ps
module bus_perm_check_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  trust_strap = 7'b0000101;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mstr = '0;
  logic        req_priv = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [4:0]  req_periph = '0;
  logic        req_grant, req_error;
  logic [31:0] periph_sel;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_mstr = '0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_wr_err;

  always #5 clk = ~clk;

  bus_perm_check u_dut (
    .clk(clk), .rst_n(rst_n), .trust_strap(trust_strap),
    .req_valid(req_valid), .req_mstr(req_mstr), .req_priv(req_priv),
    .req_kind(req_kind), .req_periph(req_periph),
    .req_grant(req_grant), .req_error(req_error), .periph_sel(periph_sel),
    .reg_wr(reg_wr), .reg_mstr(reg_mstr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wr_err(reg_wr_err)
  );

  int  n_vec = 0;
  int  n_miss = 0;
  bit  done = 1'b0;

  // shadow of the control state, kept from the requirements
  logic [7:0]  sh_mpr;
  logic [16:0] sh_wp, sh_so;
  logic [3:0]  sh_g [2];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7/R8 table: sup rd, sup wr, sup ex, usr rd, usr wr, usr ex
  function automatic logic [5:0] code_rights(input logic [3:0] c);
    case (c)
      4'd0: return 6'b110000;
      4'd1: return 6'b100000;
      4'd2: return 6'b111000;
      4'd3: return 6'b101000;
      4'd4: return 6'b110100;
      4'd5: return 6'b110110;
      4'd6: return 6'b111101;
      4'd7: return 6'b111111;
      4'd8: return 6'b100100;
      4'd9: return 6'b101101;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic bit exp_ok(input int m, input bit p, input int k, input int t);
    bit sup;
    logic [5:0] r;
    sup = p && sh_mpr[m];                       // R2
    if (k == 3) return 1'b0;                    // R1
    if (t < 17) begin                           // R6, R12
      if (sh_so[t] && !sup) return 1'b0;
      if (k == 2 && sh_wp[t]) return 1'b0;
      return 1'b1;
    end
    r = code_rights((t == 31) ? sh_g[1] : sh_g[0]);
    case (k)
      0:       return sup ? r[3] : r[0];
      1:       return sup ? r[5] : r[2];
      default: return sup ? r[4] : r[1];
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    int k;
    if (a == 0) return sh_mpr;
    if (a >= 1 && a <= 9) begin
      k = a - 1;
      if (2*k + 1 < 17)
        return {sh_wp[2*k], sh_so[2*k], 2'b00, sh_wp[2*k+1], sh_so[2*k+1], 2'b00};
      return {sh_wp[2*k], sh_so[2*k], 6'b000000};
    end
    if (a == 10) return {4'h0, sh_g[0]};
    if (a == 11) return {4'h0, sh_g[1]};
    return 8'h00;
  endfunction

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    #2;
    check(tag, {56'h0, reg_rdata}, {56'h0, exp_rd(a)});
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 16; a++) rd_chk(a, tag);
  endtask

  // R4: error flag in the write cycle, shadow updated only when trusted
  task automatic wr_reg(input int m, input int a, input logic [7:0] d);
    int k;
    @(negedge clk);
    reg_wr = 1'b1; reg_mstr = 3'(m); reg_addr = 4'(a); reg_wdata = d;
    #2;
    check("R4 wr_err", {63'h0, reg_wr_err}, {63'h0, !sh_mpr[m]});
    @(posedge clk);
    if (sh_mpr[m]) begin
      if (a == 0) sh_mpr = d;
      else if (a >= 1 && a <= 9) begin
        k = a - 1;
        sh_wp[2*k] = d[7]; sh_so[2*k] = d[6];
        if (2*k + 1 < 17) begin sh_wp[2*k+1] = d[3]; sh_so[2*k+1] = d[2]; end
      end
      else if (a == 10) sh_g[0] = d[3:0];
      else if (a == 11) sh_g[1] = d[3:0];
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // R1 R2 R6 R7 R8 R10 R11 R12: every master, privilege, kind and target
  task automatic sweep();
    bit ok;
    string tag;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 4; k++)
          for (int t = 0; t < 32; t++) begin
            @(negedge clk);
            req_valid = 1'b1; req_mstr = 3'(m); req_priv = p[0];
            req_kind = 2'(k); req_periph = 5'(t);
            #2;
            ok = exp_ok(m, p[0], k, t);
            if (k == 3)      tag = "R1 access";
            else if (t < 17) tag = "R6 access";
            else             tag = "R7 access";
            check(tag, {30'h0, req_grant, req_error, periph_sel},
                  {30'h0, ok, !ok, ok ? (32'h1 << t) : 32'h0});
          end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [7:1] s);
    @(negedge clk);
    rst_n = 1'b0; trust_strap = s; reg_wr = 1'b0; req_valid = 1'b0;
    sh_mpr = 8'h01; sh_wp = '0; sh_so = '1; sh_g[0] = '0; sh_g[1] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 4'd0;
    #2;
    check("R3 before strap load", {56'h0, reg_rdata}, {56'h0, 8'h01});
    sh_mpr = {s, 1'b1};
    rd_chk(0, "R3 after strap load");
  endtask

  initial begin
    do_reset(7'b0000101);               // masters 1 and 3 trusted -> 0x0B
    check("R3 value", {56'h0, reg_rdata}, {56'h0, 8'h0B});
    rd_all("R9 reset value");
    sweep();

    // R10: idle request gives no response and no select
    for (int t = 0; t < 32; t += 5) begin
      @(negedge clk);
      req_valid = 1'b0; req_periph = 5'(t); req_mstr = 3'd0; req_priv = 1'b1; req_kind = 2'd1;
      #2;
      check("R10 idle", {30'h0, req_grant, req_error, periph_sel}, 64'h0);
    end

    // R4: untrusted master 2 cannot change anything
    wr_reg(2, 1, 8'hFF);
    wr_reg(2, 10, 8'h07);
    wr_reg(2, 0, 8'hFF);
    rd_all("R4 after rejected writes");

    // R5 R6: trusted writes, reserved bits masked
    for (int k = 0; k < 9; k++) wr_reg((k % 2 == 0) ? 1 : 3, k + 1, 8'(k * 37 + 8'h5A));
    wr_reg(0, 12, 8'hFF);               // unmapped: ignored
    wr_reg(0, 15, 8'hA5);
    rd_all("R5 readback");
    sweep();

    // R7 R8: every code on both grouped registers
    for (int c = 0; c < 16; c++) begin
      wr_reg(0, 10, 8'(8'hF0 | c));
      wr_reg(3, 11, 8'(15 - c));
      rd_chk(10, "R5 code0 readback");
      rd_chk(11, "R5 code1 readback");
      sweep();
    end

    // R2: master 3 loses trust and is forced to user
    wr_reg(0, 0, 8'h03);
    rd_chk(0, "R2 trust readback");
    wr_reg(3, 2, 8'h00);                // now rejected
    rd_chk(2, "R4 after trust removal");
    sweep();

    // R3: different straps on a second reset
    do_reset(7'b0000010);
    check("R3 value second", {56'h0, reg_rdata}, {56'h0, 8'h05});
    rd_all("R9 second reset value");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule